// File: doc/BRIEF.md
# Bucket Time-Code Encoder

This block turns each clock bucket into one 6-bit time code. In every bucket it looks at three things: the lock flag of the delay line, the level of the threshold discriminator at the start of the bucket, and whether a rising discriminator edge was caught during the bucket. When a rising edge was caught, the block also reads a thermometer-coded snapshot of the delay-line taps, which the external latch froze at that edge.

A rising edge that starts from a low level produces a fine-time bin number from 0 to NTAP-1. Three reserved codes sit at the top of the code space:
- 2^W-3 means the delay line is not locked.
- 2^W-2 means the discriminator was already high when the bucket began.
- 2^W-1 means the level stayed low and no edge arrived.

The discriminator level comes from another timing domain, so it passes through a synchronizer chain before it is used. The code is registered once per clock.

Top module: `tdc_bucket_encoder`

## Requirements
- R1: While reset is asserted, and before the first clock edge after release, the output code is the no-lock code 61.
- R2: When the lock input is low at a rising edge, the output after that edge is 61, whatever the discriminator, edge-flag and tap inputs are.
- R3: When locked and the synchronized start level is high, the output after the edge is 62, and the edge flag and taps have no effect.
- R4: When locked, the start level is low and the edge flag is low, the output after the edge is 63.
- R5: When locked, the start level is low and the edge flag is high, the output is a bin number. Tap bit 0 is the earliest tap. If z is the index of the lowest tap bit that is 0, the bin is z-1, or 0 when z is 0.
- R6: A tap snapshot with all NTAP bits set to 1 yields bin NTAP-1, which is 49.
- R7: Bubbles in the snapshot (a 0 with 1s above it) resolve to the lowest 1-to-0 boundary. Later boundaries are ignored.
- R8: A change of the raw discriminator level reaches the output on the third rising edge after it: two synchronizer stages, then the code register.
- R9: Codes 50 to 60 never appear on the output.
- R10: A change of the lock, edge-flag or tap inputs reaches the output on the first rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bucket clock, one bucket per period |
| rst_n | input | 1 | Active-low synchronous reset |
| dll_locked | input | 1 | High when the delay line is locked |
| disc_raw | input | 1 | Discriminator level, not yet synchronized |
| rise_seen | input | 1 | High when a rising discriminator edge was latched in this bucket |
| tap_snap | input | NTAP (50) | Thermometer snapshot of the delay-line taps taken at the edge |
| tdc_code | output | CODE_W (6) | Registered time code |

## Verification
The bench builds the block with its default values: 50 taps, a 6-bit code and two synchronizer stages. With these values the reserved codes are 61 to 63 and the unused gap is 50 to 60. The bench can therefore reach the top bin (all taps set), bin 0 from both an empty snapshot and a single set tap, and bubbled snapshots whose later boundaries must be ignored. Because the stage count is 2, the bench can check the exact three-edge latency of a discriminator change against the one-edge latency of the other inputs.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;

  // Which of the four outcomes a bucket falls into.
  typedef enum logic [1:0] {
    CLS_NOLOCK     = 2'd0,
    CLS_START_HIGH = 2'd1,
    CLS_IDLE       = 2'd2,
    CLS_HIT        = 2'd3
  } bucket_cls_e;

  // The reserved codes occupy the top three values of a w-bit code.
  function automatic int reserved_code(input int w, input bucket_cls_e c);
    int top;
    top = (1 << w) - 1;
    case (c)
      CLS_NOLOCK:     reserved_code = top - 2;
      CLS_START_HIGH: reserved_code = top - 1;
      default:        reserved_code = top;
    endcase
  endfunction

endpackage

// File: rtl/tdc_sync_chain.sv
module tdc_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int WARM_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[gi] <= 1'b0;
        else if (gi == 0) stage_q[gi] <= d;
        else stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

  // Edges since reset, saturating at STAGES, so the delay check looks back
  // only into cycles that come after reset.
  logic [WARM_W-1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != WARM_W'(STAGES)) warm_q <= warm_q + 1'b1;
  end

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == WARM_W'(STAGES)) |-> (q == $past(d, STAGES)));

endmodule

// File: rtl/tdc_thermo_locate.sv
module tdc_thermo_locate #(
  parameter int NTAP  = 50,
  parameter int BIN_W = 6
) (
  input  logic [NTAP-1:0]  taps,
  output logic [BIN_W-1:0] bin
);
  // zero_seen[i]: some tap below index i is 0.
  logic [NTAP:0]   zero_seen;
  logic [NTAP-1:0] first_zero;

  assign zero_seen[0] = 1'b0;

  generate
    for (genvar gi = 0; gi < NTAP; gi++) begin : g_scan
      assign first_zero[gi]    = ~taps[gi] & ~zero_seen[gi];
      assign zero_seen[gi + 1] = zero_seen[gi] | ~taps[gi];
    end
  endgenerate

  // The bin is the last 1 before the lowest 0. A snapshot with no 0 gives the top bin.
  always_comb begin
    bin = '0;
    for (int i = 1; i < NTAP; i++) begin
      if (first_zero[i]) bin = BIN_W'(i - 1);
    end
    if (!zero_seen[NTAP]) bin = BIN_W'(NTAP - 1);
  end

endmodule

// File: rtl/tdc_code_select.sv
module tdc_code_select
  import tdc_enc_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              locked,
  input  logic              start_high,
  input  logic              rise,
  input  logic [CODE_W-1:0] bin,
  output bucket_cls_e       cls,
  output logic [CODE_W-1:0] code_next
);
  // Priority order: lock first, then the start level, then the edge flag.
  always_comb begin
    if (!locked)         cls = CLS_NOLOCK;
    else if (start_high) cls = CLS_START_HIGH;
    else if (rise)       cls = CLS_HIT;
    else                 cls = CLS_IDLE;
  end

  always_comb begin
    if (cls == CLS_HIT) code_next = bin;
    else                code_next = CODE_W'(reserved_code(CODE_W, cls));
  end

endmodule

// File: rtl/tdc_bucket_encoder.sv
module tdc_bucket_encoder
  import tdc_enc_pkg::*;
#(
  parameter int NTAP        = 50,
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_locked,
  input  logic              disc_raw,
  input  logic              rise_seen,
  input  logic [NTAP-1:0]   tap_snap,
  output logic [CODE_W-1:0] tdc_code
);
  localparam logic [CODE_W-1:0] C_NOLOCK = CODE_W'(reserved_code(CODE_W, CLS_NOLOCK));
  localparam logic [CODE_W-1:0] C_START  = CODE_W'(reserved_code(CODE_W, CLS_START_HIGH));
  localparam logic [CODE_W-1:0] C_IDLE   = CODE_W'(reserved_code(CODE_W, CLS_IDLE));

  // Named internal events, brought out for the checks below.
  logic              start_high_w;
  logic [CODE_W-1:0] bin_w;
  logic [CODE_W-1:0] code_next_w;
  bucket_cls_e       cls_w;

  tdc_sync_chain #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (disc_raw),
    .q    (start_high_w)
  );

  tdc_thermo_locate #(.NTAP(NTAP), .BIN_W(CODE_W)) locate_i (
    .taps(tap_snap),
    .bin (bin_w)
  );

  tdc_code_select #(.CODE_W(CODE_W)) select_i (
    .locked    (dll_locked),
    .start_high(start_high_w),
    .rise      (rise_seen),
    .bin       (bin_w),
    .cls       (cls_w),
    .code_next (code_next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tdc_code <= C_NOLOCK;
    else        tdc_code <= code_next_w;
  end

  p_nolock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dll_locked |=> (tdc_code == C_NOLOCK));

  p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_locked && start_high_w) |=> (tdc_code == C_START));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_locked && !start_high_w && !rise_seen) |=> (tdc_code == C_IDLE));

  p_hit_bin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_locked && !start_high_w && rise_seen) |=> (tdc_code == $past(bin_w)));

  p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tdc_code) < NTAP) || (tdc_code >= C_NOLOCK));

endmodule

// File: tb/tdc_bucket_encoder_tb.sv
module tdc_bucket_encoder_tb_top;
  localparam int NTAP = 50;
  localparam int W    = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dll_locked = 1'b0;
  logic            disc_raw = 1'b0;
  logic            rise_seen = 1'b0;
  logic [NTAP-1:0] tap_snap = '0;
  logic [W-1:0]    tdc_code;

  int checks = 0;
  int fails = 0;
  int gap_hits = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tdc_bucket_encoder #(.NTAP(NTAP), .CODE_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .dll_locked(dll_locked), .disc_raw(disc_raw),
    .rise_seen(rise_seen), .tap_snap(tap_snap), .tdc_code(tdc_code)
  );

  // R9: watch every cycle for a code in the unused gap.
  always @(negedge clk) begin
    if (rst_n && tdc_code >= 6'd50 && tdc_code <= 6'd60) gap_hits++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected bin, counted independently: walk up until the first 0 tap.
  function automatic int exp_bin(input logic [NTAP-1:0] t);
    for (int i = 0; i < NTAP; i++) begin
      if (t[i] == 1'b0) return (i == 0) ? 0 : i - 1;
    end
    return NTAP - 1;
  endfunction

  function automatic logic [NTAP-1:0] thermo(input int ones);
    logic [NTAP-1:0] v;
    v = '0;
    for (int i = 0; i < ones; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Wait for every path to settle (3 edges), then sample away from the edge.
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input bit lk, input bit disc, input bit rise, input logic [NTAP-1:0] t);
    @(negedge clk);
    dll_locked = lk; disc_raw = disc; rise_seen = rise; tap_snap = t;
    settle();
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", tdc_code, 61);
    dll_locked = 1'b1; disc_raw = 1'b0; rise_seen = 1'b1; tap_snap = thermo(7);
    rst_n = 1'b1;
    check("R1 after release", tdc_code, 61);
  endtask

  task automatic t_no_lock();
    apply(1'b0, 1'b0, 1'b1, thermo(20));
    check("R2 low start", tdc_code, 61);
    apply(1'b0, 1'b1, 1'b0, '1);
    check("R2 high start", tdc_code, 61);
  endtask

  task automatic t_start_high();
    apply(1'b1, 1'b1, 1'b1, thermo(12));
    check("R3 edge flag set", tdc_code, 62);
    apply(1'b1, 1'b1, 1'b0, '0);
    check("R3 edge flag clear", tdc_code, 62);
  endtask

  task automatic t_idle();
    apply(1'b1, 1'b0, 1'b0, thermo(33));
    check("R4 idle", tdc_code, 63);
  endtask

  task automatic t_hit();
    int ks[4] = '{0, 1, 10, 25};
    foreach (ks[j]) begin
      apply(1'b1, 1'b0, 1'b1, thermo(ks[j]));
      check("R5 thermometer bin", tdc_code, exp_bin(thermo(ks[j])));
    end
    apply(1'b1, 1'b0, 1'b1, thermo(NTAP - 1));
    check("R5 second-to-top", tdc_code, NTAP - 2);
  endtask

  task automatic t_full();
    apply(1'b1, 1'b0, 1'b1, '1);
    check("R6 all ones", tdc_code, 49);
  endtask

  task automatic t_bubble();
    logic [NTAP-1:0] t;
    t = thermo(31);
    t[15] = 1'b0;
    apply(1'b1, 1'b0, 1'b1, t);
    check("R7 bubble mid", tdc_code, 14);
    t = thermo(41);
    t[3] = 1'b0;
    apply(1'b1, 1'b0, 1'b1, t);
    check("R7 bubble low", tdc_code, 2);
  endtask

  task automatic t_sync_latency();
    apply(1'b1, 1'b0, 1'b0, '0);
    disc_raw = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 edge 1 unchanged", tdc_code, 63);
    @(posedge clk); @(negedge clk);
    check("R8 edge 2 unchanged", tdc_code, 63);
    @(posedge clk); @(negedge clk);
    check("R8 edge 3 updated", tdc_code, 62);
  endtask

  task automatic t_fast_latency();
    apply(1'b1, 1'b1, 1'b0, '0);
    dll_locked = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 lock drop", tdc_code, 61);
    dll_locked = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 lock return", tdc_code, 62);
    apply(1'b1, 1'b0, 1'b1, thermo(5));
    tap_snap = thermo(40);
    @(posedge clk); @(negedge clk);
    check("R10 taps change", tdc_code, 39);
    rise_seen = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 flag drop", tdc_code, 63);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_lock();
    t_start_high();
    t_idle();
    t_hit();
    t_full();
    t_bubble();
    t_sync_latency();
    t_fast_latency();
    check("R9 gap codes seen", gap_hits, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule